// File: doc/BRIEF.md
# Peripheral Port Handshake Control Lines

This block runs the two control lines that accompany one 8-bit peripheral port. The first line is input-only. A selectable edge on it raises an interrupt flag. The second line is configurable. It can watch for edges like the first line, or it can drive the pin. As an output it can run an automatic handshake, emit a one-cycle strobe, or hold a fixed level. Four bits of a control register choose the behaviour. Software reads the two flags through a flag register and clears them by writing ones to it.

The port data register can be reached at two addresses. An access through the handshaking address, whether a read or a write, has side effects on the lines and flags. An access through the plain address has none. The block does not model the port data itself. It decodes only those two addresses to produce the side effects. Both input pins pass through a synchroniser before their edges are detected.

Top module: `hsctl_lines`

## Requirements
- R1: After synchronous reset, both flags are 0, the control field reads 0, the output enable of the second line is 0 and the driven level of the second line is 1.
- R2: Control bit 0 selects the active edge of the first line: 1 for rising, 0 for falling. That edge sets the first-line flag, which is bit 1 of the flag register at address 0xD. The flag goes high on the third rising clock edge after the pin changes.
- R3: Control bits 3:1 form the second-line mode. Modes 000 and 001 make a falling edge on the second-line input set the second-line flag, and modes 010 and 011 make a rising edge set it. That flag is bit 0 of the flag register, with the same latency as in R2. In modes 1xx the second-line flag is never set.
- R4: A read or write at the handshaking address 0x1 clears the first-line flag. In modes 000 and 010 it also clears the second-line flag.
- R5: In modes 001 and 011, an access at 0x1 leaves the second-line flag set. Writing 1 to bit 0 of the flag register clears the second-line flag, and writing 1 to bit 1 clears the first-line flag. Writing 0 to either bit has no effect.
- R6: An access at the plain address 0xF changes neither flag nor the second-line output.
- R7: In mode 100 the second line is driven. It goes low in the cycle after an access at 0x1. It stays low until the active edge of the first line, as selected by control bit 0, and then returns high.
- R8: In mode 101 an access at 0x1 drives the second line low for exactly one clock cycle after each access, and then it returns high.
- R9: The output enable is 1 in modes 1xx and 0 in modes 0xx. Mode 110 drives 0 and mode 111 drives 1.
- R10: The control field is written through bits 3:0 at address 0xC and reads back there with bits 7:4 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| l1_pin | input | 1 | First, input-only control line |
| l2_pin_in | input | 1 | Second control line, input side |
| l2_pin_out | output | 1 | Second control line, driven level |
| l2_pin_oe | output | 1 | Output enable of the second line |
| l1_flag | output | 1 | First-line interrupt flag |
| l2_flag | output | 1 | Second-line interrupt flag |

## Verification
A pin change reaches its flag on the third rising edge after it: two synchroniser stages, then the flag register. The bench therefore changes pins on a falling edge, confirms the flag is still clear after two edges and checks it set after three or four. Register accesses and the handshake or strobe level take effect one edge after the strobe. Each access is held for one cycle and its result is sampled at the next falling edge. The strobe is checked again one cycle later to confirm it has ended. Read data is combinational, so it is sampled 1 ns after the address is driven.

// File: rtl/hsctl_pkg.sv
package hsctl_pkg;

    typedef enum logic [2:0] {
        L2_IN_FALL  = 3'b000,
        L2_IRQ_FALL = 3'b001,
        L2_IN_RISE  = 3'b010,
        L2_IRQ_RISE = 3'b011,
        L2_HSHAKE   = 3'b100,
        L2_PULSE    = 3'b101,
        L2_LOW      = 3'b110,
        L2_HIGH     = 3'b111
    } l2_mode_e;

    typedef struct packed {
        l2_mode_e mode;     // bits 3:1
        logic     l1_rise;  // bit 0
    } ctrl_t;

    typedef struct packed {
        logic l1;           // bit 1
        logic l2;           // bit 0
    } flags_t;

    function automatic logic mode_drives(l2_mode_e m);
        return m[2];
    endfunction

    function automatic logic mode_rising(l2_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_access_clears(l2_mode_e m);
        return !m[2] && !m[0];
    endfunction

endpackage

// File: rtl/hsctl_edge.sv
module hsctl_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sr;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sr[0] <= 1'b0;
                    else     sr[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sr[i] <= 1'b0;
                    else     sr[i] <= sr[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sr[STAGES-1];
    end

    assign rise = sr[STAGES-1] & ~prev;
    assign fall = ~sr[STAGES-1] & prev;

endmodule

// File: rtl/hsctl_l2_drive.sv
module hsctl_l2_drive
    import hsctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  l2_mode_e mode,
    input  logic     hs_acc,
    input  logic     l1_edge,
    output logic     out,
    output logic     oe
);
    logic hs_lvl;
    logic pulse_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_lvl   <= 1'b1;
            pulse_lo <= 1'b0;
        end else begin
            if (mode != L2_HSHAKE) hs_lvl <= 1'b1;
            else if (hs_acc)       hs_lvl <= 1'b0;
            else if (l1_edge)      hs_lvl <= 1'b1;
            pulse_lo <= hs_acc && (mode == L2_PULSE);
        end
    end

    always_comb begin
        unique case (mode)
            L2_HSHAKE: out = hs_lvl;
            L2_PULSE:  out = ~pulse_lo;
            L2_LOW:    out = 1'b0;
            default:   out = 1'b1;
        endcase
    end

    assign oe = mode_drives(mode);

    // R7
    hs_goes_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == L2_HSHAKE && hs_acc) |=> !out);

    // R7
    hs_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == L2_HSHAKE && l1_edge && !hs_acc) |=> (out || mode != L2_HSHAKE));

    // R8
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == L2_PULSE && !out && !hs_acc) |=> (out || mode != L2_PULSE));

endmodule

// File: rtl/hsctl_lines.sv
module hsctl_lines
    import hsctl_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] HS_ADDR     = 4'h1,
    parameter logic [ADDR_W-1:0] NOHS_ADDR   = 4'hF,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'hC,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 4'hD,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              l1_pin,
    input  logic              l2_pin_in,
    output logic              l2_pin_out,
    output logic              l2_pin_oe,
    output logic              l1_flag,
    output logic              l2_flag
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLAG_W = $bits(flags_t);

    ctrl_t  ctrl;
    flags_t flags;
    logic   hs_acc, nohs_acc, flag_wr;
    logic   l1_rise, l1_fall, l2_rise, l2_fall;
    logic   l1_edge, l2_edge;
    logic   unused_bits;

    assign unused_bits = ^wdata[7:CTRL_W];
    assign hs_acc      = (rd || wr) && addr == HS_ADDR;
    assign nohs_acc    = (rd || wr) && addr == NOHS_ADDR;
    assign flag_wr     = wr && addr == FLAG_ADDR;

    hsctl_edge #(.STAGES(SYNC_STAGES)) u_l1_edge (
        .clk(clk), .rst(rst), .pin(l1_pin), .rise(l1_rise), .fall(l1_fall)
    );

    hsctl_edge #(.STAGES(SYNC_STAGES)) u_l2_edge (
        .clk(clk), .rst(rst), .pin(l2_pin_in), .rise(l2_rise), .fall(l2_fall)
    );

    assign l1_edge = ctrl.l1_rise ? l1_rise : l1_fall;
    assign l2_edge = !mode_drives(ctrl.mode) &&
                     (mode_rising(ctrl.mode) ? l2_rise : l2_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr && addr == CTRL_ADDR) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (l1_edge)
                flags.l1 <= 1'b1;
            else if (hs_acc || (flag_wr && wdata[1]))
                flags.l1 <= 1'b0;

            if (l2_edge)
                flags.l2 <= 1'b1;
            else if ((hs_acc && mode_access_clears(ctrl.mode)) || (flag_wr && wdata[0]))
                flags.l2 <= 1'b0;
        end
    end

    hsctl_l2_drive u_drive (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .hs_acc(hs_acc),
        .l1_edge(l1_edge), .out(l2_pin_out), .oe(l2_pin_oe)
    );

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR)      rdata[CTRL_W-1:0] = ctrl;
        else if (addr == FLAG_ADDR) rdata[FLAG_W-1:0] = flags;
    end

    assign l1_flag = flags.l1;
    assign l2_flag = flags.l2;

    // R2
    l1_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        l1_edge |=> l1_flag);

    // R4
    l1_hs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_acc && !l1_edge) |=> !l1_flag);

    // R5
    indep_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_acc && l2_flag && !mode_drives(ctrl.mode) && ctrl.mode[0]) |=> l2_flag);

    // R6
    nohs_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (nohs_acc && l1_flag && l2_flag) |=> (l1_flag && l2_flag));

    // R3
    out_mode_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_drives(ctrl.mode) && !l2_flag && !(wr && addr == CTRL_ADDR)) |=> !l2_flag);

endmodule

// File: tb/tb_hsctl_lines.sv
module tb_hsctl_lines;
    localparam logic [3:0] A_HS = 4'h1, A_NOHS = 4'hF, A_CTRL = 4'hC, A_FLAG = 4'hD;

    logic       clk = 0, rst = 1;
    logic [3:0] addr = 0;
    logic       rd = 0, wr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       l1_pin = 0, l2_pin_in = 0;
    logic       l2_pin_out, l2_pin_oe, l1_flag, l2_flag;
    int         checks = 0, failures = 0;

    always #2 clk = ~clk;

    hsctl_lines dut (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
        .rdata(rdata), .l1_pin(l1_pin), .l2_pin_in(l2_pin_in),
        .l2_pin_out(l2_pin_out), .l2_pin_oe(l2_pin_oe),
        .l1_flag(l1_flag), .l2_flag(l2_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc(input logic [3:0] a, input bit is_wr, input logic [7:0] d);
        addr = a; rd = !is_wr; wr = is_wr; wdata = d;
        @(negedge clk);
        rd = 0; wr = 0;
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        addr = a; rd = 1;
        #1 chk(tag, rdata, exp);
        @(negedge clk);
        rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] m;
        wait_n(3);
        rst = 0;
        wait_n(1);
        // R1 reset state
        chk("R1 flags", {l1_flag, l2_flag}, 0);
        chk("R1 oe", l2_pin_oe, 0);
        chk("R1 out", l2_pin_out, 1);
        rdchk("R1 ctrl", A_CTRL, 0);

        // R2 latency: flag set on third edge after pin change
        acc(A_CTRL, 1, 8'h01);
        l1_pin = 1; wait_n(2);
        chk("R2 latency early", l1_flag, 0);
        wait_n(1);
        chk("R2 latency due", l1_flag, 1);
        l1_pin = 0; wait_n(4);
        acc(A_FLAG, 1, 8'h03);

        // sweep all 16 control values
        for (int c = 0; c < 16; c++) begin
            m = c[3:1];
            acc(A_CTRL, 1, 8'(c));
            rdchk("R10 ctrl readback", A_CTRL, 8'(c));
            chk("R9 oe", l2_pin_oe, {7'b0, m[2]});
            if (m == 3'b110) chk("R9 low", l2_pin_out, 0);
            if (m == 3'b111) chk("R9 high", l2_pin_out, 1);
            acc(A_FLAG, 1, 8'h03);
            rdchk("R5 cleared", A_FLAG, 0);

            l1_pin = 1; wait_n(4);
            chk("R2 rise", l1_flag, c[0]);
            acc(A_FLAG, 1, 8'h03);
            l1_pin = 0; wait_n(4);
            chk("R2 fall", l1_flag, !c[0]);
            acc(A_FLAG, 1, 8'h03);

            l2_pin_in = 1; wait_n(4);
            chk("R3 rise", l2_flag, !m[2] && m[1]);
            acc(A_FLAG, 1, 8'h03);
            l2_pin_in = 0; wait_n(4);
            chk("R3 fall", l2_flag, !m[2] && !m[1]);

            if (!m[2]) begin
                if (m[1]) begin l2_pin_in = 1; wait_n(4); end
                rdchk("R3 flag reg", A_FLAG, 8'h01);
                acc(A_NOHS, 0, 0);
                chk("R6 nohs keeps l2 flag", l2_flag, 1);
                acc(A_HS, 0, 0);
                chk("R4 R5 hs access on l2 flag", l2_flag, m[0]);
                acc(A_FLAG, 1, 8'h02);
                chk("R5 other bit no effect", l2_flag, m[0]);
                acc(A_FLAG, 1, 8'h01);
                chk("R5 write one clears", l2_flag, 0);
                l2_pin_in = 0; wait_n(4);
            end
            acc(A_FLAG, 1, 8'h03);
        end

        // R4 / R5 / R6 on the first-line flag
        acc(A_CTRL, 1, 8'h01);
        l1_pin = 1; wait_n(4);
        acc(A_FLAG, 1, 8'h00);
        chk("R5 write zero", l1_flag, 1);
        acc(A_NOHS, 1, 8'h55);
        chk("R6 nohs keeps l1 flag", l1_flag, 1);
        acc(A_HS, 1, 8'h55);
        chk("R4 hs clears l1 flag", l1_flag, 0);
        l1_pin = 0; wait_n(4);

        // R7 handshake, both edge selections
        for (int s = 0; s < 2; s++) begin
            acc(A_CTRL, 1, 8'(8 | s));
            chk("R7 idle high", l2_pin_out, 1);
            chk("R7 oe", l2_pin_oe, 1);
            acc(A_NOHS, 0, 0);
            chk("R6 nohs no handshake", l2_pin_out, 1);
            acc(A_HS, 0, 0);
            chk("R7 low after access", l2_pin_out, 0);
            wait_n(4);
            chk("R7 held low", l2_pin_out, 0);
            l1_pin = 1; wait_n(4);
            chk("R7 after rising edge", l2_pin_out, s[0]);
            l1_pin = 0; wait_n(4);
            chk("R7 after falling edge", l2_pin_out, 1);
        end

        // R8 pulse
        acc(A_CTRL, 1, 8'h0A);
        chk("R8 idle", l2_pin_out, 1);
        acc(A_HS, 1, 8'h00);
        chk("R8 low one cycle", l2_pin_out, 0);
        wait_n(1);
        chk("R8 back high", l2_pin_out, 1);
        acc(A_HS, 0, 0);
        acc(A_HS, 0, 0);
        chk("R8 back-to-back low", l2_pin_out, 0);
        wait_n(1);
        chk("R8 back-to-back high", l2_pin_out, 1);
        acc(A_NOHS, 1, 8'h00);
        chk("R6 nohs no pulse", l2_pin_out, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule